// File: doc/BRIEF.md
# CPU Bus Address Decoder with Transfer Acknowledge

This block sits between an 8-bit-data CPU with a 20-bit byte address and two memory-mapped targets. It splits the 1 MB space into two halves using only the top address bit. The upper half selects a 512 KB static RAM that needs no wait states. The lower half selects a slow I/O responder that decodes only the low eight address bits, so its 256-byte window repeats across the whole lower half.

The block drives an active-low chip enable to the RAM and an active-low select to the I/O responder. It forwards the address fields and the read/write line to each target. It also merges the per-target acknowledges into the CPU's active-low transfer acknowledge. A RAM access is acknowledged at once. An I/O access stalls the CPU until the responder pulses its acknowledge low for one clock. The decoder then latches that pulse, so the acknowledge stays asserted until the CPU ends the bus cycle.

Top module: `busDecoder`

## Requirements
- R1: With the strobe low and address bit 19 = 0, the I/O select is driven low and the RAM chip enable stays high in that same cycle.
- R2: With the strobe low and address bit 19 = 1, the RAM chip enable is driven low and the I/O select stays high in that same cycle.
- R3: Whenever the strobe is high, both the RAM chip enable and the I/O select are high, including the cycle in which the strobe rises.
- R4: Whenever address bit 19 = 1, the acknowledge to the CPU is low, so a RAM access completes with zero wait cycles.
- R5: When address bit 19 = 0, the acknowledge to the CPU stays high until the I/O responder drives its acknowledge low. A responder with latency L therefore stalls the CPU exactly L cycles.
- R6: The I/O address output equals address bits 7..0, so for example 0x00010 and 0x7FF10 both present offset 0x10.
- R7: The RAM address output equals address bits 18..0. The RAM write enable and the I/O read/write output both copy the CPU read/write line, where 1 means read and 0 means write.
- R8: Once the I/O responder has acknowledged, the CPU acknowledge stays low while the strobe stays low, even after the responder's one-clock pulse ends. A new I/O cycle starts with the acknowledge high.
- R9: After reset, with the strobe high and address bit 19 = 0, every select and the CPU acknowledge are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAsN | input | 1 | CPU address strobe, active low |
| cpuAddr | input | 20 | CPU byte address |
| cpuRw | input | 1 | CPU read/write, 1 = read, 0 = write |
| ioAckN | input | 1 | I/O responder acknowledge, active-low one-clock pulse |
| cpuDtackN | output | 1 | Transfer acknowledge to the CPU, active low |
| ramCeN | output | 1 | RAM chip enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramAddr | output | 19 | RAM word address |
| ioSelN | output | 1 | I/O responder select, active low |
| ioAddr | output | 8 | I/O register offset |
| ioRw | output | 1 | Read/write forwarded to the I/O responder |

## Verification
Bus cycles are run against both halves, for reads and writes, at addresses chosen so that a wrong bit in the decoder shows up. For the I/O half these are the window base, an offset high in the lower half that mirrors a low offset, and the last byte below the boundary. For the RAM half they are the first byte above the boundary and the top address. The number of stall cycles is counted for each access, which separates a RAM access (zero stalls) from an I/O access (exactly the responder latency). Holding the strobe past the acknowledge pulse shows whether the latch keeps the acknowledge asserted. Checking at the moment the strobe rises, and again at the start of the next cycle, shows whether the selects release in time and whether a stale acknowledge leaks into the next cycle.

// File: rtl/busDecPkg.sv
package busDecPkg;
  // select strobes passed from control to datapath
  typedef struct packed {
    logic ramSel;
    logic ioSel;
  } selStrobe_t;
endpackage

// File: rtl/busDecPath.sv
module busDecPath
  import busDecPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_AW  = 8,
  localparam int RAM_AW = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRw,
  input  selStrobe_t        sel,
  output logic              upperHalf,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ioSelN,
  output logic [IO_AW-1:0]  ioAddr,
  output logic              ioRw
);
  // region is chosen by the top address bit alone
  assign upperHalf = cpuAddr[ADDR_W-1];

  // RAM side: lower address bits pass straight through
  assign ramAddr = cpuAddr[RAM_AW-1:0];
  assign ramWeN  = cpuRw;
  assign ramCeN  = ~sel.ramSel;

  // I/O side: only the low byte is decoded, giving mirrors
  assign ioAddr = cpuAddr[IO_AW-1:0];
  assign ioRw   = cpuRw;
  assign ioSelN = ~sel.ioSel;
endmodule

// File: rtl/busDecCtrl.sv
module busDecCtrl
  import busDecPkg::*;
#(
  parameter bit HOLD_ACK = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuAsN,
  input  logic       upperHalf,
  input  logic       ioAckN,
  output selStrobe_t sel,
  output logic       cpuDtackN
);
  logic ackSeen;

  // selects are combinational so they release with the strobe
  always_comb begin
    sel.ramSel = ~cpuAsN & upperHalf;
    sel.ioSel  = ~cpuAsN & ~upperHalf;
  end

  generate
    if (HOLD_ACK) begin : g_hold
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          ackSeen <= 1'b0;
        else if (cpuAsN)                    ackSeen <= 1'b0;
        else if (!upperHalf && !ioAckN)     ackSeen <= 1'b1;
      end
    end else begin : g_pass
      assign ackSeen = 1'b0;
    end
  endgenerate

  always_comb begin
    if (upperHalf) cpuDtackN = 1'b0;
    else           cpuDtackN = ioAckN & ~(ackSeen & ~cpuAsN);
  end

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    cpuAsN |-> (!sel.ramSel && !sel.ioSel)); // R3
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sel.ramSel, sel.ioSel})); // R1
  AST_RAM_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuAsN && upperHalf) |-> sel.ramSel); // R2
endmodule

// File: rtl/busDecoder.sv
module busDecoder
  import busDecPkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int IO_AW    = 8,
  parameter bit HOLD_ACK = 1'b1,
  localparam int RAM_AW  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuAsN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRw,
  input  logic              ioAckN,
  output logic              cpuDtackN,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ioSelN,
  output logic [IO_AW-1:0]  ioAddr,
  output logic              ioRw
);
  selStrobe_t sel;
  logic       upperHalf;

  busDecPath #(.ADDR_W(ADDR_W), .IO_AW(IO_AW)) u_path (
    .cpuAddr(cpuAddr), .cpuRw(cpuRw), .sel(sel), .upperHalf(upperHalf),
    .ramCeN(ramCeN), .ramWeN(ramWeN), .ramAddr(ramAddr),
    .ioSelN(ioSelN), .ioAddr(ioAddr), .ioRw(ioRw)
  );

  busDecCtrl #(.HOLD_ACK(HOLD_ACK)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAsN(cpuAsN), .upperHalf(upperHalf),
    .ioAckN(ioAckN), .sel(sel), .cpuDtackN(cpuDtackN)
  );

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramCeN && !ioSelN)); // R2
  AST_RAM_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    cpuAddr[ADDR_W-1] |-> !cpuDtackN); // R4
  AST_ACK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuAsN && !cpuAddr[ADDR_W-1] && !ioAckN) |-> !cpuDtackN); // R5
  AST_FRESH_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuAsN) && !cpuAddr[ADDR_W-1] && ioAckN) |-> cpuDtackN); // R8

  generate
    if (HOLD_ACK) begin : g_holdChk
      AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rstN)
        (!cpuAsN && !cpuAddr[ADDR_W-1] &&
         $past(!cpuAsN && !cpuAddr[ADDR_W-1] && !ioAckN)) |-> !cpuDtackN); // R8
    end
  endgenerate
endmodule

// File: tb/busDecoder_bench.sv
module busDecoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IO_LAT     = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuAsN = 1'b1;
  logic [19:0] cpuAddr = '0;
  logic        cpuRw = 1'b1;
  logic        ioAckN;
  logic        cpuDtackN, ramCeN, ramWeN, ioSelN, ioRw;
  logic [18:0] ramAddr;
  logic [7:0]  ioAddr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busDecoder u_busDecoder (
    .clk(clk), .rstN(rstN), .cpuAsN(cpuAsN), .cpuAddr(cpuAddr), .cpuRw(cpuRw),
    .ioAckN(ioAckN), .cpuDtackN(cpuDtackN), .ramCeN(ramCeN), .ramWeN(ramWeN),
    .ramAddr(ramAddr), .ioSelN(ioSelN), .ioAddr(ioAddr), .ioRw(ioRw)
  );

  // I/O responder model: acknowledges IO_LAT clocks after select, one-clock pulse
  int  rspCnt;
  logic rspDone;
  always_ff @(posedge clk) begin
    if (ioSelN) begin
      rspCnt <= 0; rspDone <= 1'b0; ioAckN <= 1'b1;
    end else if (!rspDone) begin
      rspCnt <= rspCnt + 1;
      if (rspCnt == IO_LAT-1) begin ioAckN <= 1'b0; rspDone <= 1'b1; end
    end else begin
      ioAckN <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tReset();
    rstN = 1'b0; cpuAsN = 1'b1; cpuAddr = 20'h00000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R9 dtack after reset", cpuDtackN, 1);
    chk("R9 ram ce after reset", ramCeN, 1);
    chk("R9 io sel after reset", ioSelN, 1);
  endtask

  task automatic tRamCycle(input logic [19:0] a, input logic rw);
    @(negedge clk);
    cpuAddr = a; cpuRw = rw; cpuAsN = 1'b0;
    #1;
    chk("R2 ram ce", ramCeN, 0);
    chk("R2 io sel idle", ioSelN, 1);
    chk("R4 zero wait dtack", cpuDtackN, 0);
    chk("R7 ram addr", ramAddr, a[18:0]);
    chk("R7 ram we", ramWeN, rw);
    @(negedge clk);
    cpuAsN = 1'b1; #1;
    chk("R3 ram ce release", ramCeN, 1);
    chk("R4 dtack with bit19 set", cpuDtackN, 0);
  endtask

  task automatic tIoCycle(input logic [19:0] a, input logic rw, input int extra);
    int stall;
    @(negedge clk);
    cpuAddr = a; cpuRw = rw; cpuAsN = 1'b0;
    #1;
    chk("R8 new cycle dtack high", cpuDtackN, 1);
    chk("R1 io sel", ioSelN, 0);
    chk("R1 ram ce idle", ramCeN, 1);
    chk("R6 io offset", ioAddr, a[7:0]);
    chk("R7 io rw", ioRw, rw);
    stall = 0;
    while (cpuDtackN && stall < 50) begin
      @(negedge clk); #1;
      stall++;
    end
    chk("R5 stall cycles", stall, IO_LAT);
    for (int i = 0; i < extra; i++) begin
      @(negedge clk); #1;
      chk("R8 ack held", cpuDtackN, 0);
    end
    @(negedge clk);
    cpuAsN = 1'b1; #1;
    chk("R3 io sel release", ioSelN, 1);
    chk("R3 ram ce stays", ramCeN, 1);
    chk("R8 dtack released", cpuDtackN, 1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end

  initial begin
    tReset();
    tIoCycle(20'h00010, 1'b1, 0);
    tIoCycle(20'h7FF10, 1'b0, 2);   // mirror of offset 0x10
    tIoCycle(20'h7FFFF, 1'b1, 1);   // last byte below boundary
    tRamCycle(20'h80000, 1'b1);
    tRamCycle(20'hFFFFF, 1'b0);
    tIoCycle(20'h00000, 1'b0, 0);   // right after a RAM cycle
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end
endmodule